// File: doc/BRIEF.md
# Password Gate with Retry Counter

This block guards a small protected memory. A host streams a 64-bit password into it one byte at a time and picks the kind of access it wants, read or write. The block compares the assembled value against the stored read key or the stored write key. Whatever the outcome, it then holds a fixed busy interval, measured in timer ticks, and keeps the result hidden until that interval is over.

The host learns the result by polling with a particular command code. The reply is an acknowledge only when the busy interval has finished and the key matched. An acknowledge opens a grant that lasts until the current transaction closes. Failed attempts use up a retry allowance. When the allowance is gone, the block raises a request to erase the whole data array and waits for the erase to report completion.

The bus framing and the nonvolatile storage are outside this block. The stored keys arrive as plain input vectors.

Top module: `access_gate`

## Requirements
- R1: Password bytes arrive on `pwdByte`, qualified by `pwdValid`. The first byte is the most significant. After eight accepted bytes the assembled 64-bit value is compared with `readKey` if `opWrite` was low when the first byte was accepted, and with `writeKey` if it was high.
- R2: In the cycle after the eighth byte is accepted, `busy` goes high. This happens whether the password matched or not.
- R3: `busy` stays high until exactly `BUSY_TICKS` cycles with `tick` high have been counted. It is low in the cycle after the last of those ticks.
- R4: A poll is a cycle with `pollValid` high. A poll whose `pollCode` equals 0x55 produces `pollRespValid` high in the next cycle. A poll with any other code produces no response.
- R5: The poll response has `pollAck` = 1 only if `busy` was low when the poll was made and the latest attempt matched. In every other case the response is a NACK, with `pollAck` = 0.
- R6: `grant` rises together with an acknowledging response and stays high until `txnEnd`. After `txnEnd`, `grant` is low, and a new password is needed before a later poll can acknowledge.
- R7: Password bytes presented while `busy` is high are ignored. They neither start a new busy interval nor change the stored result.
- R8: Each failed attempt uses up one of eight retries. In the cycle after the eighth failure with no match in between, `clearReq` goes high.
- R9: A matching attempt restores the full allowance of eight retries.
- R10: `clearReq` stays high until `clearDone` is seen. That event restores eight retries. Password bytes presented while `clearReq` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwdValid | input | 1 | Password byte strobe |
| pwdByte | input | 8 | Password byte, most significant first |
| opWrite | input | 1 | Requested access: 1 = write, 0 = read |
| txnEnd | input | 1 | Current transaction has ended |
| pollValid | input | 1 | Poll strobe |
| pollCode | input | 8 | Command code carried by the poll |
| tick | input | 1 | Timer tick for the busy interval |
| clearDone | input | 1 | Array erase has completed |
| readKey | input | 64 | Stored read password |
| writeKey | input | 64 | Stored write password |
| busy | output | 1 | Busy interval in progress |
| pollRespValid | output | 1 | A poll response is present |
| pollAck | output | 1 | Response is ACK (1) or NACK (0) |
| grant | output | 1 | Access granted for this transaction |
| clearReq | output | 1 | Request to erase the data array |

## Verification
All results come from registers. `busy`, `grant`, `clearReq` and the poll response change at the first rising edge after the stimulus that causes them. The bench drives inputs on falling edges and samples at the next falling edge, which is half a cycle after the edge where the result becomes visible. It checks the busy length at both `BUSY_TICKS`-1 and `BUSY_TICKS` ticks, so an off-by-one in either direction fails a check. The retry tests also look at the counts one below the limit and at the limit.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam logic [7:0] POLL_CODE = 8'h55;

  typedef struct packed {
    logic capture;
    logic restart;
  } dpStrobe_t;
endpackage

// File: rtl/gate_datapath.sv
module gate_datapath
  import gate_pkg::*;
#(
  parameter int PWD_BYTES = 8,
  parameter int BYTE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  logic [BYTE_W-1:0]           pwdByte,
  input  logic                        opWrite,
  input  logic [PWD_BYTES*BYTE_W-1:0] readKey,
  input  logic [PWD_BYTES*BYTE_W-1:0] writeKey,
  output logic                        frameDone,
  output logic                        keyMatch
);
  localparam int PWD_W = PWD_BYTES * BYTE_W;
  localparam int CNT_W = $clog2(PWD_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PWD_BYTES - 1);

  logic [PWD_W-1:0] shiftReg;
  logic [CNT_W-1:0] byteCnt;
  logic             opSel;
  logic [PWD_W-1:0] candidate;

  assign candidate = {shiftReg[PWD_W-BYTE_W-1:0], pwdByte};
  assign frameDone = strobe.capture && !strobe.restart && (byteCnt == LAST);
  assign keyMatch  = candidate == (opSel ? writeKey : readKey);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      byteCnt  <= '0;
      opSel    <= 1'b0;
    end else if (strobe.restart) begin
      byteCnt <= '0;
    end else if (strobe.capture) begin
      shiftReg <= candidate;
      if (byteCnt == '0) opSel <= opWrite;
      byteCnt <= (byteCnt == LAST) ? '0 : byteCnt + 1'b1;
    end
  end
endmodule

// File: rtl/gate_control.sv
module gate_control
  import gate_pkg::*;
#(
  parameter int BUSY_TICKS = 10,
  parameter int RETRY_MAX  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwdValid,
  input  logic       txnEnd,
  input  logic       pollValid,
  input  logic [7:0] pollCode,
  input  logic       tick,
  input  logic       clearDone,
  input  logic       frameDone,
  input  logic       keyMatch,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       pollRespValid,
  output logic       pollAck,
  output logic       grant,
  output logic       clearReq
);
  localparam int TICK_W  = $clog2(BUSY_TICKS + 1);
  localparam int RETRY_W = $clog2(RETRY_MAX + 1);
  localparam logic [TICK_W-1:0]  TICK_LAST = TICK_W'(BUSY_TICKS - 1);
  localparam logic [RETRY_W-1:0] RETRY_FULL = RETRY_W'(RETRY_MAX);

  logic [TICK_W-1:0]  tickCnt;
  logic [RETRY_W-1:0] retryLeft;
  logic               matched;
  logic               pollHit;
  logic               ackNow;

  assign strobe.capture = pwdValid && !busy && !clearReq;
  assign strobe.restart = txnEnd;
  assign pollHit = pollValid && (pollCode == POLL_CODE);
  assign ackNow  = pollHit && !busy && matched;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy          <= 1'b0;
      tickCnt       <= '0;
      retryLeft     <= RETRY_FULL;
      matched       <= 1'b0;
      pollRespValid <= 1'b0;
      pollAck       <= 1'b0;
      grant         <= 1'b0;
      clearReq      <= 1'b0;
    end else begin
      pollRespValid <= pollHit;
      pollAck       <= ackNow;
      if (ackNow) grant <= 1'b1;

      if (busy && tick) begin
        if (tickCnt == TICK_LAST) busy <= 1'b0;
        else tickCnt <= tickCnt + 1'b1;
      end

      if (frameDone) begin
        busy    <= 1'b1;
        tickCnt <= '0;
        matched <= keyMatch;
        grant   <= 1'b0;
        if (keyMatch) begin
          retryLeft <= RETRY_FULL;
        end else if (retryLeft <= RETRY_W'(1)) begin
          retryLeft <= '0;
          clearReq  <= 1'b1;
        end else begin
          retryLeft <= retryLeft - 1'b1;
        end
      end

      if (clearReq && clearDone) begin
        clearReq  <= 1'b0;
        retryLeft <= RETRY_FULL;
      end

      if (txnEnd) begin
        grant   <= 1'b0;
        matched <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/access_gate.sv
module access_gate
  import gate_pkg::*;
#(
  parameter int PWD_BYTES  = 8,
  parameter int BYTE_W     = 8,
  parameter int BUSY_TICKS = 10,
  parameter int RETRY_MAX  = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pwdValid,
  input  logic [BYTE_W-1:0]           pwdByte,
  input  logic                        opWrite,
  input  logic                        txnEnd,
  input  logic                        pollValid,
  input  logic [7:0]                  pollCode,
  input  logic                        tick,
  input  logic                        clearDone,
  input  logic [PWD_BYTES*BYTE_W-1:0] readKey,
  input  logic [PWD_BYTES*BYTE_W-1:0] writeKey,
  output logic                        busy,
  output logic                        pollRespValid,
  output logic                        pollAck,
  output logic                        grant,
  output logic                        clearReq
);
  dpStrobe_t strobe;
  logic      frameDone;
  logic      keyMatch;

  gate_datapath #(.PWD_BYTES(PWD_BYTES), .BYTE_W(BYTE_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pwdByte(pwdByte),
    .opWrite(opWrite), .readKey(readKey), .writeKey(writeKey),
    .frameDone(frameDone), .keyMatch(keyMatch)
  );

  gate_control #(.BUSY_TICKS(BUSY_TICKS), .RETRY_MAX(RETRY_MAX)) uCtl (
    .clk(clk), .rstN(rstN), .pwdValid(pwdValid), .txnEnd(txnEnd),
    .pollValid(pollValid), .pollCode(pollCode), .tick(tick),
    .clearDone(clearDone), .frameDone(frameDone), .keyMatch(keyMatch),
    .strobe(strobe), .busy(busy), .pollRespValid(pollRespValid),
    .pollAck(pollAck), .grant(grant), .clearReq(clearReq)
  );
endmodule

// File: rtl/access_gate_chk.sv
module access_gate_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pwdValid,
  input logic       txnEnd,
  input logic       pollValid,
  input logic [7:0] pollCode,
  input logic       clearDone,
  input logic       busy,
  input logic       pollRespValid,
  input logic       pollAck,
  input logic       grant,
  input logic       clearReq
);
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(pwdValid));

  // R4
  resp_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollRespValid |-> $past(pollValid && pollCode == 8'h55));

  // R5
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollAck |-> (pollRespValid && $past(!busy)));

  // R6
  grant_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grant) |-> pollAck);

  // R6
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    txnEnd |=> !grant);

  // R10
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clearReq && !clearDone) |=> clearReq);
endmodule

bind access_gate access_gate_chk chk (
  .clk(clk), .rstN(rstN), .pwdValid(pwdValid), .txnEnd(txnEnd),
  .pollValid(pollValid), .pollCode(pollCode), .clearDone(clearDone),
  .busy(busy), .pollRespValid(pollRespValid), .pollAck(pollAck),
  .grant(grant), .clearReq(clearReq)
);

// File: tb/tb_access_gate.sv
`timescale 1ns/1ps
module tb_access_gate;
  localparam int BUSY_TICKS = 10;
  localparam logic [63:0] RKEY = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] WKEY = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] BAD  = 64'h0123_4567_89AB_CDEE;

  logic clk = 0, rstN = 0;
  logic pwdValid = 0, opWrite = 0, txnEnd = 0, pollValid = 0, tick = 0, clearDone = 0;
  logic [7:0] pwdByte = '0, pollCode = '0;
  logic busy, pollRespValid, pollAck, grant, clearReq;
  int checks = 0, failures = 0;
  logic rv, ra;

  always #2 clk = ~clk;

  access_gate #(.BUSY_TICKS(BUSY_TICKS)) dut (
    .clk(clk), .rstN(rstN), .pwdValid(pwdValid), .pwdByte(pwdByte),
    .opWrite(opWrite), .txnEnd(txnEnd), .pollValid(pollValid),
    .pollCode(pollCode), .tick(tick), .clearDone(clearDone),
    .readKey(RKEY), .writeKey(WKEY), .busy(busy),
    .pollRespValid(pollRespValid), .pollAck(pollAck), .grant(grant),
    .clearReq(clearReq)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic sendPwd(logic [63:0] key, logic op);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      pwdValid = 1; pwdByte = key[i*8 +: 8]; opWrite = op;
    end
    @(negedge clk);
    pwdValid = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic poll(logic [7:0] code);
    @(negedge clk); pollValid = 1; pollCode = code;
    @(negedge clk); pollValid = 0;
    rv = pollRespValid; ra = pollAck;
  endtask

  task automatic endTxn();
    @(negedge clk); txnEnd = 1;
    @(negedge clk); txnEnd = 0;
  endtask

  task automatic attempt(logic [63:0] key, logic op);
    sendPwd(key, op);
    ticks(BUSY_TICKS);
    endTxn();
  endtask

  task automatic testReset();
    check("R6 reset grant", grant, 0);
    check("R2 reset busy", busy, 0);
    check("R10 reset clearReq", clearReq, 0);
    check("R4 reset resp", pollRespValid, 0);
  endtask

  task automatic testReadGrant();
    sendPwd(RKEY, 0);
    check("R2 busy after frame", busy, 1);
    poll(8'h55);
    check("R4 resp while busy", rv, 1);
    check("R5 nack while busy", ra, 0);
    check("R6 no grant while busy", grant, 0);
    ticks(BUSY_TICKS - 1);
    check("R3 busy one tick early", busy, 1);
    ticks(1);
    check("R3 busy done", busy, 0);
    poll(8'h55);
    check("R5 ack after busy", ra, 1);
    check("R1 read key grant", grant, 1);
    poll(8'h54);
    check("R4 other code ignored", rv, 0);
    check("R6 grant held", grant, 1);
    endTxn();
    check("R6 grant cleared", grant, 0);
    poll(8'h55);
    check("R6 new pwd needed", ra, 0);
  endtask

  task automatic testWriteKey();
    sendPwd(WKEY, 1); ticks(BUSY_TICKS); poll(8'h55);
    check("R1 write key ack", ra, 1);
    endTxn();
    sendPwd(RKEY, 1); ticks(BUSY_TICKS); poll(8'h55);
    check("R1 read key on write op nack", ra, 0);
    check("R5 wrong key no grant", grant, 0);
    endTxn();
  endtask

  task automatic testIgnoreBusy();
    sendPwd(RKEY, 0);
    ticks(2);
    sendPwd(BAD, 0);
    ticks(BUSY_TICKS - 2);
    check("R7 busy not restarted", busy, 0);
    poll(8'h55);
    check("R7 result unchanged", ra, 1);
    endTxn();
  endtask

  task automatic testRetry();
    for (int i = 0; i < 7; i++) attempt(BAD, 0);
    check("R8 no clear after 7", clearReq, 0);
    sendPwd(BAD, 0);
    check("R8 clear after 8th", clearReq, 1);
    ticks(BUSY_TICKS); endTxn();
    sendPwd(RKEY, 0);
    check("R10 bytes ignored in clear", busy, 0);
    check("R10 clear held", clearReq, 1);
    @(negedge clk); clearDone = 1;
    @(negedge clk); clearDone = 0;
    check("R10 clear released", clearReq, 0);
    for (int i = 0; i < 7; i++) attempt(BAD, 0);
    check("R10 counter restored", clearReq, 0);
    attempt(RKEY, 0);
    for (int i = 0; i < 7; i++) attempt(BAD, 0);
    check("R9 match restores counter", clearReq, 0);
    sendPwd(BAD, 0);
    check("R9 clear after 8 more", clearReq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testReadGrant();
    testWriteKey();
    testIgnoreBusy();
    testRetry();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule